// File: doc/BRIEF.md
# Direct-Mapped Block Cache Controller

This controller sits between a processor port that issues 32-bit word accesses and a slower memory that answers one word per handshake. It keeps 4096 lines. Each line holds a four-word block, a tag and a valid flag. A read that finds its block returns the selected word straight from the line array. A read that does not find its block holds the processor while the controller loads the whole block, one word at a time, and then retries the lookup.

Writes go through to memory. When the target block is already cached, the word is also updated in the line. A write whose block is absent first loads that block, then merges the new word into it, and then performs the memory write. The processor keeps its request high until it sees `cpu_ack`. `cpu_stall` shows that the controller is busy with memory on its behalf.

The controller has four states:
- `ST_IDLE`: waits for a request and goes to `ST_COMPARE` when one arrives.
- `ST_COMPARE`:
  - on a read hit it acknowledges and returns to `ST_IDLE`;
  - on a write hit it updates the line and goes to `ST_WRITE_MEM`;
  - on a miss it goes to `ST_FILL`.
- `ST_FILL`: loops on itself until the fourth word is acknowledged, then goes back to `ST_COMPARE`.
- `ST_WRITE_MEM`: waits for the memory acknowledge, then acknowledges the processor and returns to `ST_IDLE`.

Top module: `dmc_cache`

## Requirements
- R1: The byte address is split into four fields: tag = bits 31:16, line index = bits 15:4, word-in-block = bits 3:2, byte = bits 1:0. Two addresses with equal index and different tags compete for one line. Addresses with different indices do not disturb each other.
- R2: A lookup hits only when the indexed line is valid and its stored tag equals the address tag. Reset clears every valid flag, so the first access after reset misses.
- R3: A read hit raises `cpu_ack`, with the selected word on `cpu_rdata`, in the cycle after the request is accepted. It makes no memory access.
- R4: A read miss issues four memory reads to the block's word addresses, in offset order 0,1,2,3. Each read waits for `mem_ack`. After the fourth, the line becomes valid with the new tag and the requested word is returned.
- R5: A write hit stores the word in the line and writes the same word to the same word-aligned address in memory. `cpu_ack` follows that memory acknowledge.
- R6: A write miss first loads the whole block (four reads), then merges the written word, then performs one memory write. The block's other words keep the values loaded from memory.
- R7: Placement is direct-mapped. Loading a block evicts whichever block occupied its index, and a later access to the evicted block misses again.
- R8: `cpu_stall` is high from the detection of a miss, or from the start of a write, until the access completes. It is low in the cycle `cpu_ack` is high and throughout a read hit.
- R9: While `mem_req` is high and `mem_ack` has not arrived, `mem_addr` and `mem_we` hold steady.
- R10: The byte bits 1:0 of `cpu_addr` are ignored. Addresses differing only there access the same word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Access request, held until `cpu_ack` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 32 | Byte address |
| cpu_wdata | input | 32 | Write word |
| cpu_rdata | output | 32 | Read word, valid with `cpu_ack` on reads |
| cpu_ack | output | 1 | Access completes this cycle |
| cpu_stall | output | 1 | Controller busy with memory for this access |
| mem_req | output | 1 | Memory request, held until `mem_ack` |
| mem_we | output | 1 | 1 = memory write, 0 = memory read |
| mem_addr | output | 32 | Word-aligned memory byte address |
| mem_wdata | output | 32 | Memory write word |
| mem_rdata | input | 32 | Memory read word, valid with `mem_ack` |
| mem_ack | input | 1 | Memory completes the request this cycle |

## Verification
The bench loads a block cold and then reads a neighbouring word. A controller that kept only one word per line, or that issued fills out of order, would either miss on that second read or log the wrong address sequence. It performs a write miss and then reads back both the written word and an untouched word of the same block. Skipping the allocation would leave the untouched word stale, and merging before the fill would let memory data overwrite the write. It sets two tags on one index against each other while a third block sits on a neighbouring index, which exposes a tag compare that ignores bits or an index taken from the wrong bits. It stretches memory latency to catch a controller that moves its address before the acknowledge.

// File: rtl/dmc_pkg.sv
package dmc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_COMPARE,
        ST_FILL,
        ST_WRITE_MEM
    } dmc_state_e;
endpackage

// File: rtl/dmc_line_store.sv
module dmc_line_store #(
    parameter int IDX_W  = 12,
    parameter int TAG_W  = 16,
    parameter int WORD_W = 32,
    parameter int WORDS  = 4
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [IDX_W-1:0]          rd_idx,
    output logic                      rd_valid,
    output logic [TAG_W-1:0]          rd_tag,
    output logic [WORDS*WORD_W-1:0]   rd_line,
    input  logic [IDX_W-1:0]          wr_idx,
    input  logic                      data_we,
    input  logic [WORDS-1:0]          wr_mask,
    input  logic [WORD_W-1:0]         wr_word,
    input  logic                      tag_we,
    input  logic [TAG_W-1:0]          tag_in,
    input  logic                      valid_in
);
    localparam int LINES = 1 << IDX_W;

    logic [LINES-1:0] valid_q;
    logic [TAG_W-1:0] tag_q [LINES];

    always_ff @(posedge clk) begin
        if (rst)
            valid_q <= '0;
        else if (tag_we)
            valid_q[wr_idx] <= valid_in;
    end

    always_ff @(posedge clk) begin
        if (tag_we)
            tag_q[wr_idx] <= tag_in;
    end

    assign rd_valid = valid_q[rd_idx];
    assign rd_tag   = tag_q[rd_idx];

    for (genvar g = 0; g < WORDS; g++) begin : g_bank
        logic [WORD_W-1:0] bank_q [LINES];
        always_ff @(posedge clk) begin
            if (data_we && wr_mask[g])
                bank_q[wr_idx] <= wr_word;
        end
        assign rd_line[g*WORD_W +: WORD_W] = bank_q[rd_idx];
    end
endmodule

// File: rtl/dmc_word_mux.sv
module dmc_word_mux #(
    parameter int WORD_W = 32,
    parameter int WORDS  = 4,
    parameter int SEL_W  = 2
) (
    input  logic [WORDS*WORD_W-1:0] line,
    input  logic [SEL_W-1:0]        sel,
    output logic [WORD_W-1:0]       word
);
    logic [WORDS-1:0][WORD_W-1:0] gated;

    for (genvar g = 0; g < WORDS; g++) begin : g_leg
        assign gated[g] = (sel == SEL_W'(g)) ? line[g*WORD_W +: WORD_W] : '0;
    end

    always_comb begin
        word = '0;
        for (int i = 0; i < WORDS; i++)
            word = word | gated[i];
    end
endmodule

// File: rtl/dmc_cache.sv
module dmc_cache
    import dmc_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int WORD_W = 32,
    parameter int IDX_W  = 12,
    parameter int OFS_W  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [WORD_W-1:0] cpu_wdata,
    output logic [WORD_W-1:0] cpu_rdata,
    output logic              cpu_ack,
    output logic              cpu_stall,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic [WORD_W-1:0] mem_rdata,
    input  logic              mem_ack
);
    localparam int BYTE_W = $clog2(WORD_W / 8);
    localparam int TAG_W  = ADDR_W - IDX_W - OFS_W - BYTE_W;
    localparam int WORDS  = 1 << OFS_W;
    localparam int WA_W   = ADDR_W - BYTE_W;

    dmc_state_e          state_q, state_d;
    logic [WA_W-1:0]     addr_q;
    logic                we_q;
    logic [WORD_W-1:0]   wdata_q;
    logic [OFS_W-1:0]    cnt_q, cnt_d;

    logic [TAG_W-1:0]    tag_f;
    logic [IDX_W-1:0]    idx_f;
    logic [OFS_W-1:0]    ofs_f;
    logic                rd_valid;
    logic [TAG_W-1:0]    rd_tag;
    logic [WORDS*WORD_W-1:0] rd_line;
    logic [WORD_W-1:0]   sel_word;
    logic                hit;
    logic                data_we, tag_we, valid_in;
    logic [WORDS-1:0]    wr_mask;
    logic [WORD_W-1:0]   wr_word;
    logic                unused_byte;

    assign unused_byte = ^cpu_addr[BYTE_W-1:0];
    assign tag_f = addr_q[WA_W-1 -: TAG_W];
    assign idx_f = addr_q[OFS_W +: IDX_W];
    assign ofs_f = addr_q[OFS_W-1:0];
    assign hit   = rd_valid && (rd_tag == tag_f);

    dmc_line_store #(.IDX_W(IDX_W), .TAG_W(TAG_W), .WORD_W(WORD_W), .WORDS(WORDS)) u_store (
        .clk(clk), .rst(rst), .rd_idx(idx_f), .rd_valid(rd_valid), .rd_tag(rd_tag),
        .rd_line(rd_line), .wr_idx(idx_f), .data_we(data_we), .wr_mask(wr_mask),
        .wr_word(wr_word), .tag_we(tag_we), .tag_in(tag_f), .valid_in(valid_in)
    );

    dmc_word_mux #(.WORD_W(WORD_W), .WORDS(WORDS), .SEL_W(OFS_W)) u_mux (
        .line(rd_line), .sel(ofs_f), .word(sel_word)
    );

    assign cpu_rdata = sel_word;
    assign mem_wdata = wdata_q;

    // State register and request capture
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            addr_q  <= '0;
            we_q    <= 1'b0;
            wdata_q <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            if (state_q == ST_IDLE && cpu_req) begin
                addr_q  <= cpu_addr[ADDR_W-1:BYTE_W];
                we_q    <= cpu_we;
                wdata_q <= cpu_wdata;
            end
        end
    end

    // Next state and outputs
    always_comb begin
        state_d   = state_q;
        cnt_d     = cnt_q;
        cpu_ack   = 1'b0;
        cpu_stall = 1'b0;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        data_we   = 1'b0;
        tag_we    = 1'b0;
        valid_in  = 1'b0;
        wr_mask   = '0;
        wr_word   = wdata_q;
        unique case (state_q)
            ST_IDLE: begin
                if (cpu_req) state_d = ST_COMPARE;
            end
            ST_COMPARE: begin
                if (!hit) begin
                    cpu_stall = 1'b1;
                    cnt_d     = '0;
                    state_d   = ST_FILL;
                end else if (we_q) begin
                    cpu_stall = 1'b1;
                    data_we   = 1'b1;
                    wr_mask   = WORDS'(1) << ofs_f;
                    state_d   = ST_WRITE_MEM;
                end else begin
                    cpu_ack = 1'b1;
                    state_d = ST_IDLE;
                end
            end
            ST_FILL: begin
                cpu_stall = 1'b1;
                mem_req   = 1'b1;
                mem_addr  = {tag_f, idx_f, cnt_q, {BYTE_W{1'b0}}};
                if (mem_ack) begin
                    data_we  = 1'b1;
                    wr_mask  = WORDS'(1) << cnt_q;
                    wr_word  = mem_rdata;
                    tag_we   = 1'b1;
                    valid_in = (cnt_q == OFS_W'(WORDS - 1));
                    cnt_d    = cnt_q + 1'b1;
                    if (cnt_q == OFS_W'(WORDS - 1)) state_d = ST_COMPARE;
                end
            end
            ST_WRITE_MEM: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = {addr_q, {BYTE_W{1'b0}}};
                cpu_stall = !mem_ack;
                if (mem_ack) begin
                    cpu_ack = 1'b1;
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assert_reset_invalid_R2: assert property (@(posedge clk) rst |=> !rd_valid);

    assert_mem_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    assert_ack_no_stall_R8: assert property (@(posedge clk) disable iff (rst)
        cpu_ack |-> !cpu_stall);

    assert_fill_done_R4: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_FILL && mem_ack && cnt_q == OFS_W'(WORDS - 1))
        |=> (state_q == ST_COMPARE && rd_valid && rd_tag == tag_f));

    assert_write_merge_R5: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_COMPARE && hit && we_q) |=> (sel_word == $past(wdata_q)));
endmodule

// File: tb/dmc_cache_tb.sv
module dmc_cache_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cpu_req = 1'b0, cpu_we = 1'b0;
    logic [31:0] cpu_addr = '0, cpu_wdata = '0;
    logic [31:0] cpu_rdata;
    logic        cpu_ack, cpu_stall;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic        mem_ack = 1'b0;

    int checks = 0, fails = 0;
    bit done = 0;
    int lat = 0;
    int rd_n = 0, wr_n = 0;
    logic [31:0] rd_log [16];
    logic [31:0] wr_addr_last, wr_data_last;
    logic [31:0] mem_wr [logic [31:0]];

    always #10 clk = ~clk;

    dmc_cache u_dut (
        .clk(clk), .rst(rst), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_ack(cpu_ack), .cpu_stall(cpu_stall),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ack(mem_ack)
    );

    function automatic logic [31:0] init_word(logic [31:0] a);
        return {a[15:2], 2'b01, ~a[31:16]};
    endfunction

    function automatic logic [31:0] mem_value(logic [31:0] a);
        logic [31:0] k = {a[31:2], 2'b00};
        if (mem_wr.exists(k)) return mem_wr[k];
        return init_word(k);
    endfunction

    task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
        end
    endtask

    // Memory responder: drives just after the rising edge
    initial begin
        int wcnt = 0;
        logic [31:0] held = '0;
        forever begin
            @(posedge clk);
            #2;
            if (mem_ack) begin
                mem_ack = 1'b0;
                wcnt = 0;
            end else if (mem_req) begin
                if (wcnt == 0) held = mem_addr;
                if (wcnt < lat) wcnt++;
                else begin
                    if (lat > 0) chk(mem_addr == held, "R9", "addr held", mem_addr, held);
                    if (mem_we) begin
                        mem_wr[{mem_addr[31:2], 2'b00}] = mem_wdata;
                        wr_n++;
                        wr_addr_last = mem_addr;
                        wr_data_last = mem_wdata;
                    end else begin
                        mem_rdata = mem_value(mem_addr);
                        if (rd_n < 16) rd_log[rd_n] = mem_addr;
                        rd_n++;
                    end
                    mem_ack = 1'b1;
                end
            end
        end
    end

    task automatic access(input bit we, input logic [31:0] a, input logic [31:0] d,
                          output logic [31:0] rd, output bit stalled, output int cyc);
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
        stalled = 0; cyc = 0; rd = '0;
        forever begin
            @(negedge clk);
            cyc++;
            if (cpu_stall) stalled = 1;
            if (cpu_ack) begin
                rd = cpu_rdata;
                break;
            end
        end
        cpu_req = 1'b0;
    endtask

    task automatic chk_fill(string req, logic [31:0] base, int first);
        for (int i = 0; i < 4; i++)
            chk(rd_log[first+i] == base + 32'(4*i), req, "fill order", rd_log[first+i], base + 32'(4*i));
    endtask

    task automatic t_reset;
        chk(!cpu_stall && !cpu_ack && !mem_req, "R2", "idle after reset",
            {29'd0, cpu_stall, cpu_ack, mem_req}, 32'd0);
    endtask

    task automatic t_cold_read;
        logic [31:0] r; bit s; int c; int r0 = rd_n;
        access(0, 32'h1234_0058, 0, r, s, c);
        chk(r == init_word(32'h1234_0058), "R4", "miss data", r, init_word(32'h1234_0058));
        chk(rd_n - r0 == 4, "R2", "cold miss reads", rd_n - r0, 4);
        chk_fill("R1", 32'h1234_0050, r0);
        chk(s, "R8", "stall on miss", {31'd0, s}, 1);
    endtask

    task automatic t_read_hit;
        logic [31:0] r; bit s; int c; int r0 = rd_n;
        access(0, 32'h1234_0054, 0, r, s, c);
        chk(r == init_word(32'h1234_0054), "R3", "hit data", r, init_word(32'h1234_0054));
        chk(rd_n == r0 && c == 1, "R3", "hit latency", c, 1);
        chk(!s, "R8", "no stall on hit", {31'd0, s}, 0);
    endtask

    task automatic t_byte_ofs;
        logic [31:0] r; bit s; int c;
        access(0, 32'h1234_005B, 0, r, s, c);
        chk(r == init_word(32'h1234_0058) && c == 1, "R10", "byte bits ignored", r, init_word(32'h1234_0058));
    endtask

    task automatic t_write_hit;
        logic [31:0] r; bit s; int c; int r0 = rd_n; int w0 = wr_n;
        access(1, 32'h1234_005C, 32'hDEAD_BEEF, r, s, c);
        chk(wr_n - w0 == 1 && rd_n == r0, "R5", "one mem write", wr_n - w0, 1);
        chk(wr_addr_last == 32'h1234_005C, "R5", "write addr", wr_addr_last, 32'h1234_005C);
        chk(wr_data_last == 32'hDEAD_BEEF, "R5", "write data", wr_data_last, 32'hDEAD_BEEF);
        chk(s, "R8", "stall on write", {31'd0, s}, 1);
        access(0, 32'h1234_005C, 0, r, s, c);
        chk(r == 32'hDEAD_BEEF && c == 1, "R5", "cache updated", r, 32'hDEAD_BEEF);
    endtask

    task automatic t_write_miss;
        logic [31:0] r; bit s; int c; int r0 = rd_n; int w0 = wr_n;
        access(1, 32'h0BEE_0124, 32'h600D_F00D, r, s, c);
        chk(rd_n - r0 == 4 && wr_n - w0 == 1, "R6", "fill then write", rd_n - r0, 4);
        chk_fill("R6", 32'h0BEE_0120, r0);
        chk(wr_addr_last == 32'h0BEE_0124, "R6", "write addr", wr_addr_last, 32'h0BEE_0124);
        access(0, 32'h0BEE_0128, 0, r, s, c);
        chk(r == init_word(32'h0BEE_0128) && c == 1, "R6", "other word kept", r, init_word(32'h0BEE_0128));
        access(0, 32'h0BEE_0124, 0, r, s, c);
        chk(r == 32'h600D_F00D && c == 1, "R6", "merged word", r, 32'h600D_F00D);
    endtask

    task automatic t_conflict;
        logic [31:0] r; bit s; int c; int r0;
        access(0, 32'h0001_0070, 0, r, s, c);
        access(0, 32'h0001_0080, 0, r, s, c);
        r0 = rd_n;
        access(0, 32'h0002_0074, 0, r, s, c);
        chk(rd_n - r0 == 4 && r == init_word(32'h0002_0074), "R7", "second tag misses", r, init_word(32'h0002_0074));
        r0 = rd_n;
        access(0, 32'h0001_0070, 0, r, s, c);
        chk(rd_n - r0 == 4, "R7", "evicted block refetched", rd_n - r0, 4);
        chk(r == init_word(32'h0001_0070), "R7", "refetch data", r, init_word(32'h0001_0070));
        r0 = rd_n;
        access(0, 32'h0001_0084, 0, r, s, c);
        chk(rd_n == r0 && r == init_word(32'h0001_0084), "R1", "neighbour index kept", r, init_word(32'h0001_0084));
    endtask

    task automatic t_latency;
        logic [31:0] r; bit s; int c; int c0;
        lat = 2;
        c0 = checks;
        access(0, 32'h00AA_0208, 0, r, s, c);
        chk(r == init_word(32'h00AA_0208), "R9", "slow miss data", r, init_word(32'h00AA_0208));
        access(1, 32'h00AA_0200, 32'h1357_9BDF, r, s, c);
        chk(wr_data_last == 32'h1357_9BDF && wr_addr_last == 32'h00AA_0200, "R9", "slow write", wr_data_last, 32'h1357_9BDF);
        chk(checks - c0 >= 7, "R9", "held checks ran", checks - c0, 7);
        lat = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_cold_read();
        t_read_hit();
        t_byte_ofs();
        t_write_hit();
        t_write_miss();
        t_conflict();
        t_latency();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL watchdog expired act=0 exp=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule